// File: doc/BRIEF.md
# Indirect-Addressed Host Register Interface

A byte-wide parallel host port into a small register bank. Most registers are reached through an index/data pair. The host first writes a register number into the index location. It then reads or writes the data location, and that access lands on the selected register. Two direct shortcuts give faster access to the registers used most often. One is a read-only window onto the head of an external teletext FIFO. The other is a window onto the interrupt status register. Both shortcuts answer only while a host-interface-enable input is high.

Event inputs set bits in a status register. The host clears a status bit by writing a 1 into its position. A mask register chooses which status bits may raise the interrupt. A configuration register holds two settings. The first is the polarity of the external interrupt pin. In active-low mode the pin is open-drain. In active-high mode the pin is push-pull. The second setting enables the output drivers of a video data bus. The FIFO storage and the video datapath sit outside this block.

Reads are combinational: `hst_rdata` is valid in the same cycle as `hst_rd`. Writes take effect at the next rising clock edge.

Top module: `hostreg_port`

## Requirements
- R1: A write to direct address 0x00 loads the index register, and a read of 0x00 returns the index. A read or write at direct address 0x01 reaches the indirect register chosen by the index: 0xB0 is FIFO data, 0xC0 is status, 0xC1 is mask and 0xC2 is configuration.
- R2: After a synchronous reset the following are all 0: the index, status, mask, polarity and video enable. As a result `irq_oe` is 0 and `vid_oe` is 0. `hst_rdata` is 0 in every cycle where `hst_rd` is low.
- R3: In the same cycle, a read of direct address 0x10 (with `hif_en` high) or of index 0xB0 through 0x01 returns `fifo_data` and raises `fifo_pop` for that cycle. If `fifo_empty` is high, the read returns 0x00 and `fifo_pop` stays low. A write to either location changes nothing.
- R4: A high bit on `evt_set` sets that status bit at the next edge. A host write of 1 into a status bit clears it, and a write of 0 leaves it unchanged. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: While `hif_en` is high, direct address 0x11 reads and write-1-clears the same status contents as index 0xC0.
- R6: The interrupt is active when any bit of (status AND mask) is 1. The mask is read and written at index 0xC1. Bit 1 of the configuration read value shows whether the interrupt is active.
- R7: With polarity bit 0 (configuration bit 0) equal to 0, `irq_out` is 0 and `irq_oe` equals the interrupt-active state. This is open-drain, active-low behaviour.
- R8: With polarity bit 0 equal to 1, `irq_oe` is 1 and `irq_out` equals the interrupt-active state. This is push-pull, active-high behaviour.
- R9: Configuration bit 2 drives `vid_oe`. In the configuration byte, bits 7..3 read 0, and writes to bit 1 are ignored.
- R10: While `hif_en` is low, direct addresses 0x10 and 0x11 are inert. Reads there return 0x00, no pop occurs, and writes leave the status unchanged.
- R11: Indices other than 0xB0, 0xC0, 0xC1 and 0xC2 read 0x00 through 0x01, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hif_en | input | 1 | Enables the direct shortcut addresses |
| hst_addr | input | 8 | Host direct address |
| hst_wdata | input | 8 | Host write data |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_rdata | output | 8 | Host read data, combinational |
| fifo_data | input | 8 | Head entry of the teletext FIFO |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | Removes the head entry this cycle |
| evt_set | input | 8 | Status set pulses, one per bit |
| irq_out | output | 1 | Interrupt pin drive level |
| irq_oe | output | 1 | Interrupt pin driver enable |
| vid_oe | output | 1 | Video data bus output enable |

## Verification
Two things can happen to the same status bit in one cycle: an event can set it, and the host can write a 1 to clear it. The bench provokes this on purpose. It pulses `evt_set` in the same cycle as a write-1 to the status alias, both on the same bit and on different bits. A behavioural model that gives the set priority judges each outcome, and so does the resulting interrupt pin level. A long randomized phase mixes sparse events with random accesses through the index path and through both shortcuts, and compares every output on every cycle.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
    localparam int unsigned DW = 8;
    typedef logic [DW-1:0] word_t;

    localparam word_t A_INDEX = 8'h00;
    localparam word_t A_DATA  = 8'h01;
    localparam word_t A_FIFO  = 8'h10;
    localparam word_t A_STAT  = 8'h11;

    localparam word_t I_FIFO  = 8'hB0;
    localparam word_t I_STAT  = 8'hC0;
    localparam word_t I_MASK  = 8'hC1;
    localparam word_t I_CFG   = 8'hC2;

    typedef enum logic [2:0] {
        T_NONE, T_INDEX, T_FIFO, T_STAT, T_MASK, T_CFG
    } tgt_e;

    typedef struct packed {
        logic ven;
        logic pol;
    } cfg_t;

    typedef struct packed {
        tgt_e tgt;
        logic rd;
        logic wr;
    } acc_t;

    function automatic tgt_e map_index(word_t i);
        case (i)
            I_FIFO:  return T_FIFO;
            I_STAT:  return T_STAT;
            I_MASK:  return T_MASK;
            I_CFG:   return T_CFG;
            default: return T_NONE;
        endcase
    endfunction

    function automatic tgt_e map_direct(word_t a, word_t idx, logic en);
        case (a)
            A_INDEX: return T_INDEX;
            A_DATA:  return map_index(idx);
            A_FIFO:  return en ? T_FIFO : T_NONE;
            A_STAT:  return en ? T_STAT : T_NONE;
            default: return T_NONE;
        endcase
    endfunction

    function automatic word_t cfg_word(cfg_t c, logic act);
        word_t w;
        w    = '0;
        w[0] = c.pol;
        w[1] = act;
        w[2] = c.ven;
        return w;
    endfunction
endpackage

// File: rtl/hostreg_decode.sv
module hostreg_decode
    import hostreg_pkg::*;
(
    input  word_t addr_i,
    input  word_t idx_i,
    input  logic  en_i,
    input  logic  rd_i,
    input  logic  wr_i,
    output acc_t  acc_o
);
    always_comb begin
        acc_o.tgt = map_direct(addr_i, idx_i, en_i);
        acc_o.rd  = rd_i;
        acc_o.wr  = wr_i;
    end
endmodule

// File: rtl/hostreg_status.sv
module hostreg_status
    import hostreg_pkg::*;
#(
    parameter int unsigned NSTAT = DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] set_i,
    input  logic [NSTAT-1:0] clr_i,
    input  logic             mask_we,
    input  logic [NSTAT-1:0] mask_d,
    output logic [NSTAT-1:0] status_o,
    output logic [NSTAT-1:0] mask_o,
    output logic             act_o
);
    logic [NSTAT-1:0] status_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | set_i;
            if (mask_we) mask_q <= mask_d;
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign act_o    = |(status_q & mask_q);

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((status_q & $past(clr_i & ~set_i)) == '0));
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));
    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((status_q ^ $past(status_q)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/hostreg_pin.sv
module hostreg_pin (
    input  logic clk,
    input  logic rst,
    input  logic pol_i,
    input  logic act_i,
    output logic irq_out,
    output logic irq_oe
);
    always_comb begin
        if (pol_i) begin
            irq_out = act_i;
            irq_oe  = 1'b1;
        end else begin
            irq_out = 1'b0;
            irq_oe  = act_i;
        end
    end

    // R7
    open_drain_chk: assert property (@(posedge clk) disable iff (rst)
        !pol_i |-> (irq_out == 1'b0));
    // R8
    push_pull_chk: assert property (@(posedge clk) disable iff (rst)
        pol_i |-> irq_oe);
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hostreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hif_en,
    input  logic [7:0] hst_addr,
    input  logic [7:0] hst_wdata,
    input  logic       hst_rd,
    input  logic       hst_wr,
    output logic [7:0] hst_rdata,
    input  logic [7:0] fifo_data,
    input  logic       fifo_empty,
    output logic       fifo_pop,
    input  logic [7:0] evt_set,
    output logic       irq_out,
    output logic       irq_oe,
    output logic       vid_oe
);
    word_t idx_q;
    cfg_t  cfg_q;
    acc_t  acc;
    word_t status, mask, clr;
    logic  act;

    hostreg_decode i_dec (
        .addr_i(hst_addr), .idx_i(idx_q), .en_i(hif_en),
        .rd_i(hst_rd), .wr_i(hst_wr), .acc_o(acc)
    );

    assign clr = (acc.wr && acc.tgt == T_STAT) ? hst_wdata : '0;

    hostreg_status #(.NSTAT(DW)) i_stat (
        .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(clr),
        .mask_we(acc.wr && acc.tgt == T_MASK), .mask_d(hst_wdata),
        .status_o(status), .mask_o(mask), .act_o(act)
    );

    hostreg_pin i_pin (
        .clk(clk), .rst(rst), .pol_i(cfg_q.pol), .act_i(act),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            cfg_q <= '0;
        end else if (acc.wr) begin
            if (acc.tgt == T_INDEX) idx_q <= hst_wdata;
            if (acc.tgt == T_CFG) begin
                cfg_q.pol <= hst_wdata[0];
                cfg_q.ven <= hst_wdata[2];
            end
        end
    end

    always_comb begin
        word_t v;
        case (acc.tgt)
            T_INDEX: v = idx_q;
            T_FIFO:  v = fifo_empty ? '0 : fifo_data;
            T_STAT:  v = status;
            T_MASK:  v = mask;
            T_CFG:   v = cfg_word(cfg_q, act);
            default: v = '0;
        endcase
        hst_rdata = acc.rd ? v : '0;
    end

    assign fifo_pop = acc.rd && acc.tgt == T_FIFO && !fifo_empty;
    assign vid_oe   = cfg_q.ven;

    // R3
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (!fifo_empty && hst_rd));
    // R10
    gated_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (!hif_en && hst_addr == A_FIFO) |-> (!fifo_pop && hst_rdata == 8'h00));
endmodule

// File: tb/test_hostreg_port.sv
module test_hostreg_port;
    logic       clk = 0;
    logic       rst = 1;
    logic       hif_en = 0;
    logic [7:0] hst_addr = 0, hst_wdata = 0;
    logic       hst_rd = 0, hst_wr = 0;
    logic [7:0] hst_rdata;
    logic [7:0] fifo_data = 0;
    logic       fifo_empty = 1;
    logic       fifo_pop;
    logic [7:0] evt_set = 0;
    logic       irq_out, irq_oe, vid_oe;

    int errors = 0, checks = 0;
    string cur_req = "R2";

    logic [7:0] m_idx = 0, m_stat = 0, m_mask = 0;
    logic       m_pol = 0, m_ven = 0;

    always #5 clk = ~clk;

    hostreg_port i_hostreg_port (
        .clk(clk), .rst(rst), .hif_en(hif_en), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rd(hst_rd), .hst_wr(hst_wr),
        .hst_rdata(hst_rdata), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .evt_set(evt_set), .irq_out(irq_out),
        .irq_oe(irq_oe), .vid_oe(vid_oe)
    );

    // 0 none, 1 index, 2 fifo, 3 status, 4 mask, 5 config
    function automatic int target();
        int t;
        t = 0;
        if (hst_addr == 8'h00) t = 1;
        else if (hst_addr == 8'h10 && hif_en) t = 2;
        else if (hst_addr == 8'h11 && hif_en) t = 3;
        else if (hst_addr == 8'h01) begin
            if (m_idx == 8'hB0) t = 2;
            else if (m_idx == 8'hC0) t = 3;
            else if (m_idx == 8'hC1) t = 4;
            else if (m_idx == 8'hC2) t = 5;
        end
        return t;
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic act;
        int t;
        logic [7:0] er;
        act = |(m_stat & m_mask);
        t = target();
        er = 0;
        if (hst_rd) begin
            case (t)
                1: er = m_idx;
                2: er = fifo_empty ? 8'h00 : fifo_data;
                3: er = m_stat;
                4: er = m_mask;
                5: er = {5'b0, m_ven, act, m_pol};
                default: er = 0;
            endcase
        end
        chk(cur_req, "rdata", hst_rdata, er);
        chk("R3", "fifo_pop", {7'b0, fifo_pop}, {7'b0, hst_rd && t == 2 && !fifo_empty});
        if (m_pol) begin
            chk("R8", "irq_out", {7'b0, irq_out}, {7'b0, act});
            chk("R8", "irq_oe", {7'b0, irq_oe}, 8'h01);
        end else begin
            chk("R7", "irq_out", {7'b0, irq_out}, 8'h00);
            chk("R7", "irq_oe", {7'b0, irq_oe}, {7'b0, act});
        end
        chk("R9", "vid_oe", {7'b0, vid_oe}, {7'b0, m_ven});
    endtask

    task automatic model_update();
        int t;
        logic [7:0] clr;
        t = target();
        clr = 0;
        if (hst_wr) begin
            case (t)
                1: m_idx = hst_wdata;
                3: clr = hst_wdata;
                4: m_mask = hst_wdata;
                5: begin m_pol = hst_wdata[0]; m_ven = hst_wdata[2]; end
                default: ;
            endcase
        end
        m_stat = (m_stat & ~clr) | evt_set;
    endtask

    // drive at negedge, compare 1 ns later, update the model at the edge
    task automatic step(logic [7:0] a, logic [7:0] wd, logic r, logic w, logic [7:0] ev);
        hst_addr = a; hst_wdata = wd; hst_rd = r; hst_wr = w; evt_set = ev;
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d); step(a, d, 0, 1, 0); endtask
    task automatic rd(logic [7:0] a);                step(a, 0, 1, 0, 0); endtask
    task automatic idle();                           step(0, 0, 0, 0, 0); endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cur_req = "R2"; idle(); rd(8'h00); rd(8'h01);

        cur_req = "R1"; wr(8'h00, 8'hC1); rd(8'h00); wr(8'h01, 8'hFF); rd(8'h01);

        cur_req = "R4"; hif_en = 1;
        step(8'h00, 0, 0, 0, 8'h05);
        cur_req = "R5"; rd(8'h11);
        cur_req = "R4"; wr(8'h11, 8'h01); rd(8'h11); wr(8'h11, 8'h00); rd(8'h11);
        step(8'h11, 8'h04, 0, 1, 8'h04); rd(8'h11);
        step(8'h11, 8'h04, 0, 1, 8'h02); rd(8'h11);
        cur_req = "R5"; wr(8'h00, 8'hC0); rd(8'h01); wr(8'h01, 8'h02); rd(8'h11);

        cur_req = "R6"; step(8'h00, 0, 0, 0, 8'h10);
        wr(8'h00, 8'hC2); rd(8'h01);
        cur_req = "R9"; wr(8'h01, 8'hFF); rd(8'h01); idle();
        cur_req = "R6"; wr(8'h11, 8'h10); rd(8'h01);
        step(8'h00, 0, 0, 0, 8'h80); rd(8'h01);
        wr(8'h00, 8'hC1); wr(8'h01, 8'h00); rd(8'h01);
        wr(8'h01, 8'h80); idle();
        cur_req = "R7"; wr(8'h00, 8'hC2); wr(8'h01, 8'h00); idle(); rd(8'h01);

        cur_req = "R3"; fifo_empty = 0; fifo_data = 8'hA5; rd(8'h10);
        fifo_empty = 1; rd(8'h10);
        fifo_empty = 0; fifo_data = 8'h3C;
        wr(8'h00, 8'hB0); rd(8'h01); wr(8'h01, 8'h77); wr(8'h10, 8'h11); rd(8'h01);

        cur_req = "R10"; hif_en = 0; rd(8'h10); rd(8'h11); wr(8'h11, 8'hFF);
        hif_en = 1; cur_req = "R10"; rd(8'h11);

        cur_req = "R11"; wr(8'h00, 8'h55); wr(8'h01, 8'hFF); rd(8'h01);
        wr(8'h00, 8'hC1); rd(8'h01);

        cur_req = "R1";
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a, d, ev;
            int k;
            k = $urandom_range(0, 5);
            a = (k == 0) ? 8'h00 : (k == 1) ? 8'h10 : (k == 2) ? 8'h11 : 8'h01;
            case ($urandom_range(0, 4))
                0: d = 8'hB0; 1: d = 8'hC0; 2: d = 8'hC1; 3: d = 8'hC2;
                default: d = $urandom;
            endcase
            if (k != 0 && $urandom_range(0, 1) == 1) d = $urandom;
            ev = $urandom & $urandom & $urandom;
            hif_en = ($urandom_range(0, 3) != 0);
            fifo_empty = ($urandom_range(0, 2) == 0);
            fifo_data = $urandom;
            case ($urandom_range(0, 2))
                0: step(a, d, 1, 0, ev);
                1: step(a, d, 0, 1, ev);
                default: step(a, d, 0, 0, ev);
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule